// File: doc/BRIEF.md
# Audio Clock Divider with Frame-Sync Realignment

This block turns one master audio clock into a family of audio-rate clocks: the sample clock fs and a set of power-of-two multiples of it (64fs, 128fs, 256fs and 512fs at the default sizes). All of them come from a single counter that spans one fs period, so every output edge is tied to one shared phase.

A periodic frame-sync pulse from the video timing defines where an audio frame starts. The pulse is brought into the master-clock domain through a two-flop synchronizer and edge detector. The first sync edge after reset, or after the lock input drops, always restarts the counter. After that the counter runs freely. At each later sync edge the block measures how far the counter sits from its zero point, as a signed wraparound distance. It restarts the counter only when that distance is larger than a tolerance window. The window is chosen by a 3-bit code held in a small register.

While lock is low, the narrowest window applies, so that no large residual offset survives the locking phase. Each restart is reported by a one-cycle strobe. A status flag shows that the outputs have been aligned at least once since reset or since the last loss of lock.

Top module: `aclk_realign_top`

## Requirements
- R1: fs_o has a period of FS_RATIO master cycles and is high for exactly half of it. mult_o[j] runs at (64·2^j)·fs with a 50% duty cycle. Every rising edge of fs_o falls in a cycle where all mult_o bits are high.
- R2: A restart happens only in response to a frame-sync rising edge. realign_o goes high in the cycle after the fourth rising clock edge that samples fsync_i high. In that cycle fs_o is 1 and mult_o is 4'b0111 (bit 3, the fastest clock, is 0), because the sync-detect cycle counts as phase 0.
- R3: The first frame-sync edge after reset restarts the counter whatever its phase.
- R4: The phase error is the counter value at the sync-detect cycle, taken as signed modulo FS_RATIO (values from FS_RATIO/2 upward are negative). A restart happens when the magnitude of the error is strictly greater than the window, for positive and for negative errors.
- R5: Window codes 3'b000, 3'b001, 3'b010 and 3'b011 select windows of 1, 2, 4 and 8 master cycles.
- R6: Any code with bit 2 set selects a 16-cycle window, and bits 1:0 are ignored.
- R7: After reset the window code is 3'b010. A cycle with win_wr_i high loads win_sel_i into the code register.
- R8: While lock_i is low, the 1-cycle window applies whatever code is stored.
- R9: A falling edge of lock_i clears aligned_o in the next cycle. The next sync edge is then a forced restart, even when the phase error is 0.
- R10: realign_o is high for exactly one cycle per restart. aligned_o rises only together with realign_o and stays high until reset or a lock fall.
- R11: In reset, realign_o and aligned_o are 0, fs_o is 1 and mult_o is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master audio clock (FS_RATIO × fs) |
| rst_i | input | 1 | Synchronous active-high reset |
| fsync_i | input | 1 | Frame-sync pulse, asynchronous to clk_i |
| lock_i | input | 1 | Master-clock lock indication, synchronous to clk_i |
| win_wr_i | input | 1 | Load strobe for the window code register |
| win_sel_i | input | 3 | Window code to load |
| fs_o | output | 1 | Sample clock, 50% duty cycle |
| mult_o | output | NUM_MULT | Clock multiples; bit j runs at 64·2^j·fs |
| realign_o | output | 1 | One-cycle strobe when the counter is restarted |
| aligned_o | output | 1 | High once the outputs have been aligned |

## Verification
The properties assume that fsync_i stays high for at least four master cycles, then stays low for at least one cycle before it rises again, and that consecutive rising edges are much further apart than the five-cycle look-back used to link a strobe to its sync edge. They also assume that lock_i is low while reset is asserted, and that it never falls in the same cycle as a sync-detect decision. The stimulus holds each sync pulse high for four cycles and spaces pulses about one fs period apart. It changes lock_i only in quiet gaps between pulses. It places each sync edge at an exact cycle offset from the previous one, so that the expected phase error is known in advance, and it walks that error across each window boundary from both sides.

// File: rtl/aclk_pkg.sv
package aclk_pkg;
  localparam int SPAN_W = 5;
  localparam logic [2:0] WIN_NARROW = 3'b000;

  // Tolerance window in master-clock cycles for a 3-bit window code.
  function automatic logic [SPAN_W-1:0] win_span(input logic [2:0] code);
    if (code[2]) return SPAN_W'(16);
    return SPAN_W'(1) << code[1:0];
  endfunction
endpackage

// File: rtl/aclk_fsync_det.sv
module aclk_fsync_det #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_i,
  input  logic async_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;
  logic              rise_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      sync_q <= '0;
      last_q <= 1'b0;
      rise_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], async_i};
      last_q <= sync_q[STAGES-1];
      rise_q <= sync_q[STAGES-1] & ~last_q;
    end
  end

  assign rise_o = rise_q;
endmodule

// File: rtl/aclk_div_chain.sv
module aclk_div_chain #(
  parameter int CNT_W          = 10,
  parameter int NUM_MULT       = 4,
  parameter int MULT_BASE_LOG2 = 6
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                load_i,
  output logic [CNT_W-1:0]    cnt_o,
  output logic                fs_o,
  output logic [NUM_MULT-1:0] mult_o
);
  // Counter bit that drives the slowest multiple; faster ones use lower bits.
  localparam int TOP_TAP = CNT_W - 1 - MULT_BASE_LOG2;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic             fs_q;

  // A restart loads 1: the decision cycle itself counts as phase 0.
  assign cnt_nxt = load_i ? CNT_W'(1) : cnt_q + 1'b1;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      cnt_q <= '0;
      fs_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_nxt;
      fs_q  <= ~cnt_nxt[CNT_W-1];
    end
  end

  for (genvar j = 0; j < NUM_MULT; j++) begin : g_mult
    logic tap_q;
    always_ff @(posedge clk_i) begin
      if (rst_i) tap_q <= 1'b1;
      else       tap_q <= ~cnt_nxt[TOP_TAP-j];
    end
    assign mult_o[j] = tap_q;
  end

  assign cnt_o = cnt_q;
  assign fs_o  = fs_q;
endmodule

// File: rtl/aclk_phase_judge.sv
module aclk_phase_judge
  import aclk_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [2:0]       code_i,
  input  logic             lock_i,
  output logic             outside_o
);
  logic [2:0]        eff_code;
  logic [SPAN_W-1:0] span;
  logic [CNT_W-1:0]  mag;

  always_comb begin
    eff_code  = lock_i ? code_i : WIN_NARROW;
    span      = win_span(eff_code);
    // Counter values in the upper half are a negative offset; take the magnitude.
    mag       = cnt_i[CNT_W-1] ? (~cnt_i + 1'b1) : cnt_i;
    outside_o = mag > {{(CNT_W-SPAN_W){1'b0}}, span};
  end
endmodule

// File: rtl/aclk_realign_top.sv
module aclk_realign_top #(
  parameter int         FS_RATIO       = 1024,
  parameter int         NUM_MULT       = 4,
  parameter int         MULT_BASE_LOG2 = 6,
  parameter int         SYNC_STAGES    = 2,
  parameter logic [2:0] DEFAULT_WIN    = 3'b010
) (
  input  logic                clk_i,
  input  logic                rst_i,
  input  logic                fsync_i,
  input  logic                lock_i,
  input  logic                win_wr_i,
  input  logic [2:0]          win_sel_i,
  output logic                fs_o,
  output logic [NUM_MULT-1:0] mult_o,
  output logic                realign_o,
  output logic                aligned_o
);
  localparam int CNT_W = $clog2(FS_RATIO);

  logic             sync_rise;
  logic             outside;
  logic             force_load;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       win_q;
  logic             lock_q;
  logic             realign_q;
  logic             aligned_q;

  aclk_fsync_det #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .async_i(fsync_i),
    .rise_o (sync_rise)
  );

  aclk_phase_judge #(.CNT_W(CNT_W)) u_judge (
    .cnt_i    (cnt),
    .code_i   (win_q),
    .lock_i   (lock_i),
    .outside_o(outside)
  );

  assign force_load = sync_rise & (~aligned_q | outside);

  aclk_div_chain #(
    .CNT_W         (CNT_W),
    .NUM_MULT      (NUM_MULT),
    .MULT_BASE_LOG2(MULT_BASE_LOG2)
  ) u_div (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .load_i(force_load),
    .cnt_o (cnt),
    .fs_o  (fs_o),
    .mult_o(mult_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      win_q     <= DEFAULT_WIN;
      lock_q    <= 1'b0;
      realign_q <= 1'b0;
      aligned_q <= 1'b0;
    end else begin
      if (win_wr_i) win_q <= win_sel_i;
      lock_q    <= lock_i;
      realign_q <= force_load;
      if (lock_q && !lock_i) aligned_q <= 1'b0;
      else if (force_load)   aligned_q <= 1'b1;
    end
  end

  assign realign_o = realign_q;
  assign aligned_o = aligned_q;
endmodule

// File: rtl/aclk_realign_chk.sv
module aclk_realign_chk #(
  parameter int NUM_MULT = 4
) (
  input logic                clk_i,
  input logic                rst_i,
  input logic                fsync_i,
  input logic                lock_i,
  input logic                fs_o,
  input logic [NUM_MULT-1:0] mult_o,
  input logic                realign_o,
  input logic                aligned_o
);
  p_strobe_pulse_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    realign_o |=> !realign_o);

  p_aligned_rise_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(aligned_o) |-> realign_o);

  p_start_phase_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    realign_o |-> (fs_o && mult_o[0]));

  p_sync_origin_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    realign_o |-> ($past(fsync_i, 4) && !$past(fsync_i, 5)));

  p_fs_edge_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    ((fs_o != $past(fs_o)) && !realign_o) |-> (mult_o == '1));

  p_lock_fall_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(lock_i) |=> !aligned_o);
endmodule

bind aclk_realign_top aclk_realign_chk #(.NUM_MULT(NUM_MULT)) u_chk (
  .clk_i    (clk_i),
  .rst_i    (rst_i),
  .fsync_i  (fsync_i),
  .lock_i   (lock_i),
  .fs_o     (fs_o),
  .mult_o   (mult_o),
  .realign_o(realign_o),
  .aligned_o(aligned_o)
);

// File: tb/aclk_realign_top_tb_top.sv
module aclk_realign_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N          = 1024;
  localparam int NM         = 4;

  logic          clk = 1'b0;
  logic          rst;
  logic          fsync;
  logic          lock;
  logic          win_wr;
  logic [2:0]    win_sel;
  logic          fs;
  logic [NM-1:0] mult;
  logic          realign;
  logic          aligned;

  aclk_realign_top #(.FS_RATIO(N), .NUM_MULT(NM)) dut_i (
    .clk_i(clk), .rst_i(rst), .fsync_i(fsync), .lock_i(lock),
    .win_wr_i(win_wr), .win_sel_i(win_sel), .fs_o(fs), .mult_o(mult),
    .realign_o(realign), .aligned_o(aligned)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_vec = 0, n_bad = 0;
  longint cyc = 0;
  bit done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // Scoreboard queues and reference model state.
  bit    q_rea[$];
  bit    q_al[$];
  string q_req[$];
  event  sync_ev;
  int     m_pos = 0;
  bit     m_aligned = 0;
  bit     m_lock = 0;
  logic [2:0] m_code = 3'b010;
  longint last_sync = 0;

  task automatic check(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int span_of(input bit lk, input logic [2:0] c);
    if (!lk) return 1;
    if (c[2]) return 16;
    return 1 << c[1:0];
  endfunction

  // Driver: place the next sync edge delta cycles off the ideal frame grid.
  task automatic send_sync(input int delta, input string req);
    longint target = last_sync + N + delta;
    int err, mag;
    bit rea;
    while (target <= cyc + 2) target += N;
    while (cyc < target) @(negedge clk);
    fsync = 1'b1;
    m_pos = int'((longint'(m_pos) + (cyc - last_sync)) % N);
    last_sync = cyc;
    err = (m_pos >= N/2) ? m_pos - N : m_pos;
    mag = (err < 0) ? -err : err;
    rea = !m_aligned || (mag > span_of(m_lock, m_code));
    if (rea) begin
      m_pos = 0;
      m_aligned = 1;
    end
    q_rea.push_back(rea);
    q_al.push_back(m_aligned);
    q_req.push_back(req);
    -> sync_ev;
    repeat (4) @(negedge clk);
    fsync = 1'b0;
  endtask

  task automatic set_win(input logic [2:0] c);
    @(negedge clk);
    win_wr = 1'b1;
    win_sel = c;
    @(negedge clk);
    win_wr = 1'b0;
    m_code = c;
  endtask

  // Monitor: pop the expectation and compare once the strobe is due.
  initial begin
    forever begin
      bit e_rea, e_al;
      string r;
      @(sync_ev);
      repeat (4) @(posedge clk);
      @(negedge clk);
      e_rea = q_rea.pop_front();
      e_al  = q_al.pop_front();
      r     = q_req.pop_front();
      check({r, " realign"}, int'(realign), int'(e_rea));
      check({r, " aligned"}, int'(aligned), int'(e_al));
      if (e_rea) begin
        check("R2 start phase fs", int'(fs), 1);
        check("R2 start phase mult", int'(mult), 7);
      end
      @(negedge clk);
      check("R10 strobe single cycle", int'(realign), 0);
    end
  end

  // R1: duty cycle and rate of every divided clock over one fs period.
  task automatic duty_check();
    int hi_fs = 0, rise_fs = 0;
    int hi_m[NM];
    int rise_m[NM];
    logic p_fs;
    logic [NM-1:0] p_m;
    foreach (hi_m[j]) begin
      hi_m[j] = 0;
      rise_m[j] = 0;
    end
    @(negedge clk);
    p_fs = fs;
    p_m = mult;
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      if (fs) hi_fs++;
      if (fs && !p_fs) rise_fs++;
      for (int j = 0; j < NM; j++) begin
        if (mult[j]) hi_m[j]++;
        if (mult[j] && !p_m[j]) rise_m[j]++;
      end
      p_fs = fs;
      p_m = mult;
    end
    check("R1 fs high count", hi_fs, N/2);
    check("R1 fs rise count", rise_fs, 1);
    for (int j = 0; j < NM; j++) begin
      check($sformatf("R1 mult[%0d] high count", j), hi_m[j], N/2);
      check($sformatf("R1 mult[%0d] rise count", j), rise_m[j], 64 << j);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_vec++;
    n_bad++;
    $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    rst = 1'b1;
    fsync = 1'b0;
    lock = 1'b0;
    win_wr = 1'b0;
    win_sel = 3'b000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 reset realign", int'(realign), 0);
    check("R11 reset aligned", int'(aligned), 0);
    check("R11 reset fs", int'(fs), 1);
    check("R11 reset mult", int'(mult), 15);
    rst = 1'b0;
    lock = 1'b1;
    m_lock = 1;
    repeat (100) @(negedge clk);
    last_sync = cyc;

    send_sync(37, "R3 first sync forced");
    send_sync(0,  "R4 zero error");
    send_sync(4,  "R7 default window +4 inside");
    send_sync(1,  "R7 default window +5 outside");
    send_sync(-4, "R4 negative -4 inside");
    send_sync(-1, "R4 negative -5 outside");
    duty_check();

    set_win(3'b000);
    send_sync(1,  "R5 code000 +1 inside");
    send_sync(1,  "R5 code000 +2 outside");
    send_sync(-1, "R5 code000 -1 inside");
    send_sync(-1, "R5 code000 -2 outside");
    set_win(3'b001);
    send_sync(2,  "R5 code001 +2 inside");
    send_sync(1,  "R5 code001 +3 outside");
    set_win(3'b011);
    send_sync(8,  "R5 code011 +8 inside");
    send_sync(1,  "R5 code011 +9 outside");
    set_win(3'b101);
    send_sync(16, "R6 code101 +16 inside");
    send_sync(1,  "R6 code101 +17 outside");
    set_win(3'b110);
    send_sync(-16, "R6 code110 -16 inside");
    set_win(3'b111);
    send_sync(-1, "R6 code111 -17 outside");

    @(negedge clk);
    lock = 1'b0;
    m_lock = 0;
    m_aligned = 0;
    @(negedge clk);
    check("R9 lock fall clears aligned", int'(aligned), 0);
    send_sync(0,  "R9 forced after lock loss");
    send_sync(1,  "R8 unlocked +1 inside");
    send_sync(1,  "R8 unlocked +2 outside");
    @(negedge clk);
    lock = 1'b1;
    m_lock = 1;
    send_sync(10, "R8 relocked wide window +10 inside");
    duty_check();

    repeat (20) @(negedge clk);
    check("R10 aligned held", int'(aligned), 1);
    finish_run();
  end
endmodule